// File: doc/BRIEF.md
# Load-Driven Frame Migration Selector

Each node of a cache-only shared memory runs this selector. The memory also schedules execution frames. The selector keeps a small table of the frames resident on the node. For each frame it holds a valid flag, an executable flag, a running flag and the node where the frame's arguments live. The node's load is the number of resident frames that carry the executable mark.

Scheduling is driven from the supply side. An overloaded node pushes a frame out, and an idle node never asks for work; it only accepts what is offered. There is no request input of any kind. When the local load is high enough above the lightest other node, the selector issues one migration command, which names a frame, a destination and whether only the executable mark moves.

The destination is chosen in three tiers, in this order:
1. A node that already holds a copy of the frame. Only the executable mark moves.
2. The node holding the frame's arguments.
3. The lightest node.

The command is held until it is acknowledged. The acknowledge strips the local executable mark, which lowers the load.

Top module: `frame_mig_sel`

## Requirements
- R1: After reset there is no pending command (`mig_valid`=0), the frame table is empty and `load_cnt` is 0.
- R2: `load_cnt` equals the number of table entries that are both valid and executable. It reflects a table write from the cycle after the write edge.
- R3: A command is raised only when `load_cnt` >= (minimum `peer_load` over the nodes other than `NODE_ID`) + `THRESH`, and a candidate frame exists. The slot of `peer_load` belonging to `NODE_ID` is ignored. The command appears on the clock edge that samples these conditions.
- R4: The migrated frame is the lowest-index entry that is valid, executable and not running. A running frame is never chosen.
- R5: If some node n other than `NODE_ID` has `copy_map[f*NODES+n]`=1 for candidate frame f, the destination is the lowest-loaded such node, ties going to the lowest index, and `mig_mark_only`=1.
- R6: Otherwise, if the frame's argument node differs from `NODE_ID`, the destination is that argument node and `mig_mark_only`=0.
- R7: Otherwise the destination is the lowest-loaded node other than `NODE_ID`, ties to the lowest index, and `mig_mark_only`=0.
- R8: At most one command is outstanding. While `mig_valid`=1 and `mig_ack`=0, the frame, destination and flag stay unchanged.
- R9: On an edge with `mig_valid`=1 and `mig_ack`=1, the command drops and the frame loses its executable mark. `load_cnt` is one lower in the next cycle, and the frame is not offered again. A move that is not mark-only also invalidates the entry.
- R10: A table write with `upd_valid`=0 frees the entry. `upd_exec` is ignored for an invalid entry, and the entry does not count toward the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Write one frame-table entry |
| upd_idx | input | FW | Entry index to write |
| upd_valid | input | 1 | Entry resident |
| upd_exec | input | 1 | Entry holds the executable mark |
| upd_run | input | 1 | Entry is the frame currently executing |
| upd_arg | input | NW | Node holding the frame's arguments |
| peer_load | input | NODES*LW | Load of each node, LW bits per node |
| copy_map | input | FRAMES*NODES | Bit f*NODES+n set: node n holds a copy of frame f |
| mig_ack | input | 1 | Pending command accepted |
| mig_valid | output | 1 | Migration command pending |
| mig_frame | output | FW | Frame to migrate |
| mig_dest | output | NW | Destination node |
| mig_mark_only | output | 1 | Only the executable mark moves |
| load_cnt | output | LW | Local executable frame count |

## Verification
`load_cnt` is combinational on the table, so it is due in the cycle after the write edge. The bench writes on a falling edge and reads at the next falling edge, one rising edge later.

A command is registered on the first rising edge that sees the trigger condition. The bench therefore sets `peer_load` and `copy_map` on a falling edge and checks the command at the next falling edge.

The effect of an acknowledge is also due one edge later. The command has dropped and the load is lower, and this is read at the falling edge after the acknowledge edge. Until a case is staged completely, the peer loads are held at their maximum so that nothing fires early.

// File: rtl/frame_mig_sel.sv
module frame_mig_sel #(
  parameter int NODES   = 4,
  parameter int FRAMES  = 16,
  parameter int NODE_ID = 0,
  parameter int THRESH  = 2,
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LW = $clog2(FRAMES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [FW-1:0]            upd_idx,
  input  logic                     upd_valid,
  input  logic                     upd_exec,
  input  logic                     upd_run,
  input  logic [NW-1:0]            upd_arg,
  input  logic [NODES*LW-1:0]      peer_load,
  input  logic [FRAMES*NODES-1:0]  copy_map,
  input  logic                     mig_ack,
  output logic                     mig_valid,
  output logic [FW-1:0]            mig_frame,
  output logic [NW-1:0]            mig_dest,
  output logic                     mig_mark_only,
  output logic [LW-1:0]            load_cnt
);

  localparam int CW = LW + 2;

  logic [FRAMES-1:0] valid_q, exec_q, run_q;
  logic [NW-1:0]     arg_q [FRAMES];

  logic [LW-1:0] min_other;
  logic [FW-1:0] cand;
  logic          has_cand;
  logic [NW-1:0] copy_dest, light_dest, pick_dest;
  logic          has_copy, pick_mark, fire;

  function automatic logic [LW-1:0] ld_of(input int n);
    return peer_load[n*LW +: LW];
  endfunction

  always_comb begin
    load_cnt = '0;
    for (int i = 0; i < FRAMES; i++)
      load_cnt = load_cnt + LW'(valid_q[i] & exec_q[i]);
  end

  always_comb begin
    min_other  = '1;
    light_dest = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (n != NODE_ID && ld_of(n) <= min_other) begin
        min_other  = ld_of(n);
        light_dest = NW'(n);
      end
  end

  always_comb begin
    has_cand = 1'b0;
    cand     = '0;
    for (int i = FRAMES - 1; i >= 0; i--)
      if (valid_q[i] && exec_q[i] && !run_q[i]) begin
        has_cand = 1'b1;
        cand     = FW'(i);
      end
  end

  always_comb begin
    has_copy  = 1'b0;
    copy_dest = '0;
    for (int n = 0; n < NODES; n++)
      if (n != NODE_ID && copy_map[int'(cand)*NODES + n] &&
          (!has_copy || ld_of(n) < ld_of(int'(copy_dest)))) begin
        has_copy  = 1'b1;
        copy_dest = NW'(n);
      end
  end

  always_comb begin
    pick_mark = 1'b0;
    if (has_copy) begin
      pick_dest = copy_dest;
      pick_mark = 1'b1;
    end else if (int'(arg_q[cand]) != NODE_ID) begin
      pick_dest = arg_q[cand];
    end else begin
      pick_dest = light_dest;
    end
  end

  assign fire = has_cand && (CW'(load_cnt) >= CW'(min_other) + CW'(THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q       <= '0;
      exec_q        <= '0;
      run_q         <= '0;
      for (int i = 0; i < FRAMES; i++) arg_q[i] <= NW'(NODE_ID);
      mig_valid     <= 1'b0;
      mig_frame     <= '0;
      mig_dest      <= '0;
      mig_mark_only <= 1'b0;
    end else begin
      if (mig_valid && mig_ack) begin
        mig_valid         <= 1'b0;
        exec_q[mig_frame] <= 1'b0;
        if (!mig_mark_only) valid_q[mig_frame] <= 1'b0;
      end else if (!mig_valid && fire) begin
        mig_valid     <= 1'b1;
        mig_frame     <= cand;
        mig_dest      <= pick_dest;
        mig_mark_only <= pick_mark;
      end
      if (upd_en) begin
        valid_q[upd_idx] <= upd_valid;
        exec_q[upd_idx]  <= upd_valid & upd_exec;
        run_q[upd_idx]   <= upd_valid & upd_run;
        arg_q[upd_idx]   <= upd_arg;
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !mig_valid && load_cnt == '0);

  a_r3_trigger_margin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mig_valid) |-> int'($past(load_cnt)) >= int'($past(min_other)) + THRESH);

  a_r4_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mig_valid) |-> !(($past(run_q) >> mig_frame) & 1));

  a_r5_mark_needs_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mig_valid) && mig_mark_only |->
      (($past(copy_map) >> (int'(mig_frame) * NODES + int'(mig_dest))) & 1));

  a_r7_dest_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> int'(mig_dest) != NODE_ID);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid && !mig_ack |=> mig_valid && $stable(mig_frame) &&
      $stable(mig_dest) && $stable(mig_mark_only));

  a_r9_load_drop: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid && mig_ack && !upd_en |=> !mig_valid && load_cnt == $past(load_cnt) - 1'b1);

endmodule

// File: tb/frame_mig_sel_bench.sv
module frame_mig_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4, FRAMES = 16, NODE_ID = 0, THRESH = 2;
  localparam int FW = 4, NW = 2, LW = 5;

  logic clk = 0, rst_n = 0;
  logic upd_en = 0, upd_valid = 0, upd_exec = 0, upd_run = 0, mig_ack = 0;
  logic [FW-1:0] upd_idx = '0;
  logic [NW-1:0] upd_arg = '0;
  logic [NODES*LW-1:0] peer_load = '1;
  logic [FRAMES*NODES-1:0] copy_map = '0;
  logic mig_valid, mig_mark_only;
  logic [FW-1:0] mig_frame;
  logic [NW-1:0] mig_dest;
  logic [LW-1:0] load_cnt;

  int checks = 0, errors = 0;
  int pl [NODES];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_mig_sel #(.NODES(NODES), .FRAMES(FRAMES), .NODE_ID(NODE_ID), .THRESH(THRESH)) u_frame_mig_sel (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx), .upd_valid(upd_valid),
    .upd_exec(upd_exec), .upd_run(upd_run), .upd_arg(upd_arg), .peer_load(peer_load),
    .copy_map(copy_map), .mig_ack(mig_ack), .mig_valid(mig_valid), .mig_frame(mig_frame),
    .mig_dest(mig_dest), .mig_mark_only(mig_mark_only), .load_cnt(load_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input bit e, input bit r, input int a);
    @(negedge clk);
    upd_en = 1; upd_idx = FW'(idx); upd_valid = v; upd_exec = e; upd_run = r; upd_arg = NW'(a);
    @(negedge clk);
    upd_en = 0;
  endtask

  task automatic set_loads(input int l0, input int l1, input int l2, input int l3);
    pl[0] = l0; pl[1] = l1; pl[2] = l2; pl[3] = l3;
    for (int n = 0; n < NODES; n++) peer_load[n*LW +: LW] = LW'(pl[n]);
  endtask

  task automatic ack_it();
    @(negedge clk); mig_ack = 1;
    @(negedge clk); mig_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp_d; bit exp_m; int c; int pat;
    set_loads(31, 31, 31, 31);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", mig_valid, 0);
    chk("R1 load", load_cnt, 0);

    // R2: load counts valid executable entries
    for (int k = 0; k < FRAMES; k++) begin
      wr(k, 1, 1, 0, 0);
      chk("R2 fill", load_cnt, k + 1);
    end
    // R10: invalid write frees entry, exec ignored
    for (int k = FRAMES - 1; k >= 0; k--) begin
      wr(k, 0, 1, 0, 0);
      chk("R10 free", load_cnt, k);
    end
    chk("R3 no fire at high peers", mig_valid, 0);

    // running frames 1..3 count but never migrate
    for (int k = 1; k < 4; k++) wr(k, 1, 1, 1, 0);
    chk("R2 running counted", load_cnt, 3);

    // R3: threshold sweep with candidate frame 0, load 4
    for (int m = 0; m < 6; m++) begin
      wr(0, 1, 1, 0, 0);
      set_loads(31, m, m + 1, m);
      @(negedge clk);
      chk("R3 threshold", mig_valid, (4 >= m + THRESH) ? 1 : 0);
      if (mig_valid) ack_it();
      set_loads(31, 31, 31, 31);
    end

    // R4: all low entries running, frame 7 is the candidate
    wr(0, 1, 1, 1, 0);
    wr(7, 1, 1, 0, 0);
    set_loads(31, 0, 0, 0);
    @(negedge clk);
    chk("R4 valid", mig_valid, 1);
    chk("R4 skips running", mig_frame, 7);
    ack_it();
    chk("R9 no reoffer", mig_valid, 0);
    @(negedge clk);
    chk("R4 all running none", mig_valid, 0);
    chk("R9 load after ack", load_cnt, 4);
    set_loads(31, 31, 31, 31);
    wr(0, 0, 0, 0, 0);

    // R5/R6/R7 sweep over copy maps, argument node and load patterns
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < NODES; a++)
        for (int cm = 0; cm < 16; cm++) begin
          c = cm; pat = p;
          wr(0, 1, 1, 0, a);
          copy_map = '0;
          copy_map[3:0] = 4'(c);
          if (pat == 0) set_loads(31, 2, 1, 1);
          else if (pat == 1) set_loads(31, 0, 2, 0);
          else set_loads(31, 1, 1, 1);
          exp_d = -1; exp_m = 0;
          for (int n = 1; n < NODES; n++)
            if (c[n] && (exp_d < 0 || pl[n] < pl[exp_d])) exp_d = n;
          if (exp_d >= 0) exp_m = 1;
          else if (a != NODE_ID) exp_d = a;
          else begin
            exp_d = 1;
            for (int n = 2; n < NODES; n++) if (pl[n] < pl[exp_d]) exp_d = n;
          end
          @(negedge clk);
          chk("R5 R6 R7 valid", mig_valid, 1);
          chk("R4 frame", mig_frame, 0);
          chk(exp_m ? "R5 dest" : (a != NODE_ID ? "R6 dest" : "R7 dest"), mig_dest, exp_d);
          chk("R5 mark only", mig_mark_only, exp_m);
          if (cm == 5) begin
            set_loads(31, 0, 0, 0);
            copy_map = '0;
            repeat (3) @(negedge clk);
            chk("R8 hold valid", mig_valid, 1);
            chk("R8 hold dest", mig_dest, exp_d);
            chk("R8 hold mark", mig_mark_only, exp_m);
          end
          ack_it();
          chk("R9 drop", mig_valid, 0);
          chk("R9 load", load_cnt, 3);
          set_loads(31, 31, 31, 31);
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule